// File: doc/BRIEF.md
# Receive Alarm Interrupt Register Block

This block gathers eight receive-side alarm and error events from a line framer and turns them into a single active-low interrupt request. A byte-wide register bus gives software access to two registers. The mask register at 0x12 is read/write and holds one enable per source. The event register at 0x13 is read-only and clear-on-read, and holds one latched flag per source. The framer logic delivers each event as a single-cycle pulse on its own bit of `evt_pulse`. An event is recorded only when its source is enabled at that moment. The request pin is low while any latched flag is set and still enabled.

Bus reads are sequenced by a small state machine. The state names the kind of read that was accepted on the previous edge:

- `BUS_IDLE`: no read was accepted.
- `BUS_RD_MASK`: the mask register was read.
- `BUS_RD_EVT`: the event register was read.
- `BUS_RD_NONE`: any other address was read.

On every edge the machine moves from any state to one of these four, chosen by the strobe and address of that cycle:

- `rd_stb` low leads to `BUS_IDLE`.
- A read of 0x12 leads to `BUS_RD_MASK`.
- A read of 0x13 leads to `BUS_RD_EVT`.
- A read of any other address leads to `BUS_RD_NONE`.

The value is captured on the same edge, and `rd_data` shows it for the following cycle only.

The bit order is fixed and is the same in both registers:

| Bit | Source |
|-----|--------|
| 7 | C-bit parity error |
| 6 | loss of signal |
| 5 | alarm indication signal |
| 4 | idle pattern |
| 3 | remote defect indication |
| 2 | application-identification change |
| 1 | out-of-frame change |
| 0 | P-bit parity error |

Top module: `rx_alarm_irq_regs`

## Requirements
- R1: After reset the mask and event registers are 0x00, `irq_n` is 1 and `rd_data` is 0x00.
- R2: A write strobe to address 0x12 loads `wr_data` into the mask register on that edge; a read of 0x12 returns it. A write of 1 enables a source and a write of 0 disables it.
- R3: An event pulse on `evt_pulse[i]` while mask bit i is 1 sets event bit i. The bit positions follow the table above, from bit 7 (C-bit parity error) down to bit 0 (P-bit parity error).
- R4: An event pulse on a source whose mask bit is 0 is not recorded, and a later read of 0x13 shows that bit as 0.
- R5: A read of 0x13 returns the register value as it was before the edge, then clears every bit that was set. A second read with no new events returns 0x00.
- R6: An enabled event that arrives in the same cycle as a clearing read of 0x13 leaves its bit set. That read does not show the new bit; the next read does.
- R7: `irq_n` is 0 while any event bit is set and its mask bit is 1, and 1 otherwise. It returns to 1 in the cycle after the read that clears the last set bit.
- R8: A read of any address other than 0x12 or 0x13 returns 0x00 and leaves the event register unchanged. Writes to any address other than 0x12, including 0x13, change neither register.
- R9: `rd_data` shows the value captured by a read strobe during exactly the next cycle, and is 0x00 in every cycle that does not follow a read.
- R10: Clearing a mask bit after its event bit is set keeps the event bit latched and readable, but removes it from the `irq_n` request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Register address |
| rd_stb | input | 1 | Read strobe, one cycle per access |
| wr_stb | input | 1 | Write strobe, one cycle per access |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, valid the cycle after `rd_stb` |
| evt_pulse | input | 8 | Single-cycle event pulses, one per source |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The assertions assume that the bus inputs and the event pulses are stable around the sampling edge. They also assume that a read and a write in the same cycle are two separate actions: the read captures values from before the edge, and the write lands on that edge. The stimulus drives every input just after the falling edge, so each cycle carries one settled combination. Random cycles mix reads and writes of both register addresses and of foreign addresses with sparse random event pulses. This covers overlap of events with clearing reads, and simultaneous read and write strobes, without leaving those assumptions.

// File: rtl/rxai_pkg.sv
package rxai_pkg;

    localparam int unsigned NUM_SRC     = 8;
    localparam int unsigned ADDR_BITS   = 8;
    localparam int unsigned MASK_ADDR   = 'h12;
    localparam int unsigned EVT_ADDR    = 'h13;

    // Bit index of each receive source inside both registers.
    typedef enum int unsigned {
        SRC_PBIT_ERR = 0,
        SRC_FRAME    = 1,
        SRC_APP_ID   = 2,
        SRC_RDI      = 3,
        SRC_IDLE     = 4,
        SRC_AIS      = 5,
        SRC_LOS      = 6,
        SRC_CBIT_ERR = 7
    } src_idx_e;

    // Kind of read accepted on the previous edge.
    typedef enum logic [1:0] {
        BUS_IDLE    = 2'd0,
        BUS_RD_MASK = 2'd1,
        BUS_RD_EVT  = 2'd2,
        BUS_RD_NONE = 2'd3
    } bus_state_e;

endpackage

// File: rtl/rxai_mask_reg.sv
module rxai_mask_reg #(
    parameter int unsigned NSRC      = 8,
    parameter int unsigned AW        = 8,
    parameter int unsigned REG_ADDR  = 'h12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_stb,
    input  logic [AW-1:0]   addr,
    input  logic [NSRC-1:0] wr_data,
    output logic [NSRC-1:0] mask_q
);

    localparam logic [AW-1:0] HIT = AW'(REG_ADDR);

    logic hit_wr;
    assign hit_wr = wr_stb && (addr == HIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (hit_wr) begin
            mask_q <= wr_data;
        end
    end

endmodule

// File: rtl/rxai_event_reg.sv
module rxai_event_reg #(
    parameter int unsigned NSRC      = 8,
    parameter int unsigned AW        = 8,
    parameter int unsigned REG_ADDR  = 'h13
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd_stb,
    input  logic [AW-1:0]   addr,
    input  logic [NSRC-1:0] evt_pulse,
    input  logic [NSRC-1:0] mask_q,
    output logic [NSRC-1:0] evt_q
);

    localparam logic [AW-1:0] HIT = AW'(REG_ADDR);

    logic clr;
    assign clr = rd_stb && (addr == HIT);

    // One latch cell per source: a new enabled event beats the clear.
    for (genvar i = 0; i < NSRC; i++) begin : g_cell
        logic set_i;
        assign set_i = evt_pulse[i] && mask_q[i];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                evt_q[i] <= 1'b0;
            end else if (set_i) begin
                evt_q[i] <= 1'b1;
            end else if (clr) begin
                evt_q[i] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/rxai_bus_fsm.sv
module rxai_bus_fsm #(
    parameter int unsigned NSRC      = 8,
    parameter int unsigned AW        = 8,
    parameter int unsigned MASK_ADDR = 'h12,
    parameter int unsigned EVT_ADDR  = 'h13
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd_stb,
    input  logic [AW-1:0]   addr,
    input  logic [NSRC-1:0] mask_q,
    input  logic [NSRC-1:0] evt_q,
    output logic [NSRC-1:0] rd_data
);

    import rxai_pkg::*;

    localparam logic [AW-1:0] A_MASK = AW'(MASK_ADDR);
    localparam logic [AW-1:0] A_EVT  = AW'(EVT_ADDR);

    bus_state_e      state_q;
    bus_state_e      state_d;
    logic [NSRC-1:0] cap_d;
    logic [NSRC-1:0] cap_q;

    // Next state and capture value from the current access.
    always_comb begin
        state_d = BUS_IDLE;
        cap_d   = '0;
        if (rd_stb) begin
            if (addr == A_MASK) begin
                state_d = BUS_RD_MASK;
                cap_d   = mask_q;
            end else if (addr == A_EVT) begin
                state_d = BUS_RD_EVT;
                cap_d   = evt_q;
            end else begin
                state_d = BUS_RD_NONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BUS_IDLE;
            cap_q   <= '0;
        end else begin
            state_q <= state_d;
            cap_q   <= cap_d;
        end
    end

    always_comb begin
        unique case (state_q)
            BUS_IDLE:    rd_data = '0;
            BUS_RD_MASK: rd_data = cap_q;
            BUS_RD_EVT:  rd_data = cap_q;
            BUS_RD_NONE: rd_data = '0;
            default:     rd_data = '0;
        endcase
    end

endmodule

// File: rtl/rx_alarm_irq_regs.sv
module rx_alarm_irq_regs #(
    parameter int unsigned NSRC      = rxai_pkg::NUM_SRC,
    parameter int unsigned AW        = rxai_pkg::ADDR_BITS,
    parameter int unsigned MASK_ADDR = rxai_pkg::MASK_ADDR,
    parameter int unsigned EVT_ADDR  = rxai_pkg::EVT_ADDR
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   addr,
    input  logic            rd_stb,
    input  logic            wr_stb,
    input  logic [NSRC-1:0] wr_data,
    output logic [NSRC-1:0] rd_data,
    input  logic [NSRC-1:0] evt_pulse,
    output logic            irq_n
);

    logic [NSRC-1:0] mask_q;
    logic [NSRC-1:0] evt_q;

    rxai_mask_reg #(.NSRC(NSRC), .AW(AW), .REG_ADDR(MASK_ADDR)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (wr_stb),
        .addr    (addr),
        .wr_data (wr_data),
        .mask_q  (mask_q)
    );

    rxai_event_reg #(.NSRC(NSRC), .AW(AW), .REG_ADDR(EVT_ADDR)) u_evt (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_stb    (rd_stb),
        .addr      (addr),
        .evt_pulse (evt_pulse),
        .mask_q    (mask_q),
        .evt_q     (evt_q)
    );

    rxai_bus_fsm #(.NSRC(NSRC), .AW(AW), .MASK_ADDR(MASK_ADDR), .EVT_ADDR(EVT_ADDR)) u_bus (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_stb  (rd_stb),
        .addr    (addr),
        .mask_q  (mask_q),
        .evt_q   (evt_q),
        .rd_data (rd_data)
    );

    assign irq_n = ~|(evt_q & mask_q);

endmodule

// File: rtl/rxai_checker.sv
module rxai_checker #(
    parameter int unsigned NSRC = rxai_pkg::NUM_SRC,
    parameter int unsigned AW   = rxai_pkg::ADDR_BITS
) (
    input logic            clk,
    input logic            rst_n,
    input logic [AW-1:0]   addr,
    input logic            rd_stb,
    input logic            wr_stb,
    input logic [NSRC-1:0] wr_data,
    input logic [NSRC-1:0] rd_data,
    input logic [NSRC-1:0] evt_pulse,
    input logic            irq_n,
    input logic [NSRC-1:0] mask_q,
    input logic [NSRC-1:0] evt_q
);

    localparam logic [AW-1:0] A_MASK = AW'(rxai_pkg::MASK_ADDR);
    localparam logic [AW-1:0] A_EVT  = AW'(rxai_pkg::EVT_ADDR);

    logic rd_evt;
    logic rd_other;
    assign rd_evt   = rd_stb && (addr == A_EVT);
    assign rd_other = rd_stb && (addr != A_EVT) && (addr != A_MASK);

    assert_mask_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_stb && addr == A_MASK) |-> mask_q == $past(wr_data));

    assert_no_record_disabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_q & ~$past(evt_q)) & ~$past(mask_q)) == '0);

    assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_evt && evt_pulse == '0) |-> evt_q == '0);

    assert_event_beats_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_evt) |-> (evt_q & $past(evt_pulse & mask_q)) == $past(evt_pulse & mask_q));

    assert_irq_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_evt && evt_pulse == '0) |-> irq_n);

    assert_irq_on_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(|(evt_pulse & mask_q)) && $past(!(wr_stb && addr == A_MASK)) |-> !irq_n);

    assert_other_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_other) |-> rd_data == '0);

    assert_other_read_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_other) |-> (evt_q & $past(evt_q)) == $past(evt_q));

    assert_quiet_bus_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rd_stb) |-> rd_data == '0);

endmodule

bind rx_alarm_irq_regs rxai_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (addr),
    .rd_stb    (rd_stb),
    .wr_stb    (wr_stb),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .evt_pulse (evt_pulse),
    .irq_n     (irq_n),
    .mask_q    (mask_q),
    .evt_q     (evt_q)
);

// File: tb/rx_alarm_irq_regs_tb.sv
module rx_alarm_irq_regs_tb;

    localparam logic [7:0] A_MASK = 8'h12;
    localparam logic [7:0] A_EVT  = 8'h13;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] addr = '0;
    logic       rd_stb = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [7:0] evt_pulse = '0;
    logic       irq_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference state
    logic [7:0] m_mask = '0;
    logic [7:0] m_evt  = '0;

    always #10 clk = ~clk;

    rx_alarm_irq_regs u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (addr),
        .rd_stb    (rd_stb),
        .wr_stb    (wr_stb),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .evt_pulse (evt_pulse),
        .irq_n     (irq_n)
    );

    function automatic logic [7:0] exp_read(logic [7:0] a);
        if (a == A_MASK) return m_mask;
        if (a == A_EVT)  return m_evt;
        return 8'h00;
    endfunction

    function automatic logic exp_irq();
        return ~|(m_evt & m_mask);
    endfunction

    task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // One bus cycle: drive after the falling edge, update model at the rising edge,
    // compare at the next falling edge.
    task automatic step(string tag, logic [7:0] a, logic r, logic w,
                        logic [7:0] wd, logic [7:0] ev);
        logic [7:0] exp_rd;
        addr = a; rd_stb = r; wr_stb = w; wr_data = wd; evt_pulse = ev;
        @(posedge clk);
        exp_rd = r ? exp_read(a) : 8'h00;
        if (r && a == A_EVT) m_evt = 8'h00;
        m_evt = m_evt | (ev & m_mask);
        if (w && a == A_MASK) m_mask = wd;
        @(negedge clk);
        check8({tag, " rd_data"}, rd_data, exp_rd);
        check8({tag, " irq_n"}, {7'd0, irq_n}, {7'd0, exp_irq()});
    endtask

    task automatic idle(string tag);
        step(tag, 8'h00, 1'b0, 1'b0, 8'h00, 8'h00);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check8("R1 reset rd_data", rd_data, 8'h00);
        check8("R1 reset irq_n", {7'd0, irq_n}, 8'h01);
        rst_n = 1'b1;
        step("R1 mask after reset", A_MASK, 1, 0, 0, 0);
        step("R1 evt after reset", A_EVT, 1, 0, 0, 0);

        // R4: events with everything masked are dropped
        step("R4 masked pulse", 8'h00, 0, 0, 0, 8'hFF);
        step("R4 readback", A_EVT, 1, 0, 0, 0);

        // R2: mask write and readback
        step("R2 write", A_MASK, 0, 1, 8'hA5, 0);
        step("R2 readback", A_MASK, 1, 0, 0, 0);
        step("R2 write all", A_MASK, 0, 1, 8'hFF, 0);

        // R3: each source sets its own bit (bit7 C-bit ... bit0 P-bit)
        for (int i = 0; i < 8; i++) begin
            step("R3 pulse", 8'h00, 0, 0, 0, 8'(1 << i));
            step("R3 read", A_EVT, 1, 0, 0, 0);
        end

        // R5: clear on read then zero
        step("R5 pulse", 8'h00, 0, 0, 0, 8'h81);
        step("R5 first read", A_EVT, 1, 0, 0, 0);
        step("R5 second read", A_EVT, 1, 0, 0, 0);
        step("R7 after clear", 8'h00, 0, 0, 0, 0);

        // R6: event during clearing read
        step("R6 prime", 8'h00, 0, 0, 0, 8'h02);
        step("R6 overlap read", A_EVT, 1, 0, 0, 8'h40);
        step("R6 next read", A_EVT, 1, 0, 0, 0);

        // R8: foreign addresses
        step("R8 pulse", 8'h00, 0, 0, 0, 8'h10);
        step("R8 foreign read", 8'h14, 1, 0, 0, 0);
        step("R8 write evt addr", A_EVT, 0, 1, 8'h00, 0);
        step("R8 foreign write", 8'h11, 0, 1, 8'h00, 0);
        step("R8 mask kept", A_MASK, 1, 0, 0, 0);
        step("R8 evt kept", A_EVT, 1, 0, 0, 0);

        // R9: rd_data for a single cycle only
        step("R9 read", A_MASK, 1, 0, 0, 0);
        idle("R9 after read");

        // R10: masking a latched bit
        step("R10 pulse", 8'h00, 0, 0, 0, 8'h08);
        step("R10 unmask", A_MASK, 0, 1, 8'hF7, 0);
        step("R10 still latched", A_EVT, 1, 0, 0, 0);
        step("R10 restore", A_MASK, 0, 1, 8'hFF, 0);

        // Random mix
        for (int n = 0; n < 3000; n++) begin
            logic [7:0] a;
            logic [7:0] ev;
            int sel;
            sel = int'($urandom_range(0, 9));
            if (sel < 4)      a = A_EVT;
            else if (sel < 7) a = A_MASK;
            else              a = 8'($urandom);
            ev = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'h00;
            step("R7 R9 random", a, 1'($urandom_range(0, 1)),
                 ($urandom_range(0, 5) == 0), 8'($urandom), ev);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule